// File: doc/BRIEF.md
# Halt-Based Cycle-Stealing DMA Engine

This block copies a run of bytes from one place in a 20-bit physical address space to another, for a system built around an 8-bit processor bus. It does not share the bus through arbitration. It raises a halt request to the processor, waits until the processor signals that it has released the bus, and then performs the copy itself. Each byte it moves is a bus cycle the processor loses. Each byte is moved with one read strobe and then one write strobe. An internal holding register carries the byte from the read to the write.

Software sets the engine up through a byte-wide register window. This window holds the source pointer, the destination pointer, the byte count, a mode and start register, and a status register. The source pointer and the destination pointer can each be set to advance after every byte or to stay fixed. A fixed pointer suits a peripheral data port, which has a single address. When the count reaches zero, the engine releases the halt request and raises an interrupt. The interrupt stays high until software writes one to the done bit.

The register offsets for the default parameters are:

- 0, 1, 2: source pointer, least significant byte first.
- 3, 4, 5: destination pointer, least significant byte first.
- 6, 7: count, least significant byte first.
- 8: mode and start register.
- 9: status register.

Top module: `halt_dma`

## Requirements
- R1: After reset the outputs are idle: halt_req, irq, mem_rd and mem_wr are 0. All registers read back 0.
- R2: A start with a nonzero count raises halt_req in the cycle after the start write. The engine never asserts mem_rd or mem_wr unless halt_ack and halt_req are both 1.
- R3: Each byte takes one mem_rd strobe and then one mem_wr strobe. The byte written is the byte returned by the read that came before it. mem_rd and mem_wr are never high together.
- R4: Mode register bit 1 makes the source pointer advance by one after each read. Mode bit 2 makes the destination pointer advance by one after each write. When a bit is 0, that pointer stays fixed. Both pointers read back their current values.
- R5: Each pointer is 20 bits wide and is loaded by three byte writes: offsets 0 to 2 for the source and 3 to 5 for the destination. Only the low 4 bits of the top byte are kept. An increment carries across byte boundaries.
- R6: The count is 16 bits wide, at offsets 6 (low byte) and 7 (high byte). Exactly that many bytes are moved, and the count reads 0 at the end.
- R7: A start with a count of zero sets done and irq at the start write itself. It raises no halt_req and drives no strobe.
- R8: After the final write, halt_req falls and irq rises in the very next cycle.
- R9: Status bit 0 shows that a transfer is in progress. Status bit 1 shows done, and irq follows it. Writing 1 to status bit 1 clears done and irq. A new start also clears done.
- R10: While a transfer is in progress, writes to the pointer, count and mode registers are ignored, and so is any further start bit (mode bit 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 4 | Register offset for the processor access |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the offset on reg_sel |
| irq | output | 1 | Transfer-complete interrupt |
| halt_req | output | 1 | Halt request to the processor |
| halt_ack | input | 1 | Processor has released the bus |
| mem_addr | output | 20 | Physical address of the current bus cycle |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_rdata | input | 8 | Data returned by the read |
| mem_wdata | output | 8 | Data for the write |

## Verification
The bench sweeps the copy over these inputs:

- Counts of 0, 1, 2, 3, 5, 16 and 259. The 259-byte count needs the high count byte.
- All four settings of the two increment bits. With every pointer advancing, the destination receives an exact copy. With a fixed source, the destination is filled with one byte. With a fixed destination, it ends up holding the last source byte. With both fixed, the same single byte is rewritten over and over.
- A grant that arrives either at once or after a delay. This separates an engine that waits for halt_ack from one that drives strobes as soon as it starts.

The source pointer starts two bytes below a 256-byte boundary, so any carry error shows up in the addresses that are read back. Register writes made during a long grant delay show whether the busy lockout works.

// File: rtl/halt_dma_pkg.sv
package halt_dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_RD   = 2'd2,
    ST_WR   = 2'd3
  } dma_state_e;

  localparam int MODE_GO      = 0;
  localparam int MODE_SRC_INC = 1;
  localparam int MODE_DST_INC = 2;
  localparam int STAT_BUSY    = 0;
  localparam int STAT_DONE    = 1;
endpackage

// File: rtl/halt_dma_rst_sync.sv
module halt_dma_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/halt_dma_cnt.sv
module halt_dma_cnt #(
  parameter int W          = 20,
  parameter bit COUNT_DOWN = 1'b0,
  localparam int NB    = (W + 7) / 8,
  localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_byte,
  input  logic             step,
  output logic [W-1:0]     value
);
  logic [W-1:0] val_q;
  logic [W-1:0] val_d;
  logic         val_en;

  always_comb begin
    val_d = val_q;
    if (wr_en) begin
      for (int i = 0; i < W; i++) begin
        if (wr_idx == IDX_W'(i / 8)) val_d[i] = wr_byte[i % 8];
      end
    end else if (step) begin
      val_d = COUNT_DOWN ? (val_q - W'(1)) : (val_q + W'(1));
    end
  end

  assign val_en = wr_en | step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_q <= '0;
    else if (val_en) val_q <= val_d;
  end

  assign value = val_q;
endmodule

// File: rtl/halt_dma_seq.sv
module halt_dma_seq
  import halt_dma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic cnt_zero,
  input  logic cnt_last,
  input  logic halt_ack,
  output logic busy,
  output logic bus_rd,
  output logic bus_wr,
  output logic done_set
);
  dma_state_e state_q;
  dma_state_e state_d;

  always_comb begin
    state_d  = state_q;
    done_set = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (go) begin
          if (cnt_zero) done_set = 1'b1;
          else          state_d  = ST_REQ;
        end
      end
      ST_REQ: if (halt_ack) state_d = ST_RD;
      ST_RD:  if (halt_ack) state_d = ST_WR;
      ST_WR: begin
        if (halt_ack) begin
          if (cnt_last) begin
            state_d  = ST_IDLE;
            done_set = 1'b1;
          end else begin
            state_d  = ST_RD;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy   = (state_q != ST_IDLE);
  assign bus_rd = (state_q == ST_RD) && halt_ack;
  assign bus_wr = (state_q == ST_WR) && halt_ack;
endmodule

// File: rtl/halt_dma.sv
module halt_dma
  import halt_dma_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int LEN_W  = 16,
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_sel,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq,
  output logic              halt_req,
  input  logic              halt_ack,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  input  logic [7:0]        mem_rdata,
  output logic [7:0]        mem_wdata
);
  localparam int NB_A    = (ADDR_W + 7) / 8;
  localparam int NB_L    = (LEN_W + 7) / 8;
  localparam int AIDX_W  = (NB_A > 1) ? $clog2(NB_A) : 1;
  localparam int LIDX_W  = (NB_L > 1) ? $clog2(NB_L) : 1;
  localparam int LEN_OFS = 2 * NB_A;
  localparam int CTL_OFS = LEN_OFS + NB_L;
  localparam int STS_OFS = CTL_OFS + 1;

  logic              rst_n_i;
  logic              busy;
  logic              bus_rd;
  logic              bus_wr;
  logic              done_set;
  logic              cfg_wr;
  logic              ctl_we;
  logic              go;
  logic              sts_clr;
  logic              src_inc_q;
  logic              dst_inc_q;
  logic              done_q;
  logic              done_d;
  logic              done_en;
  logic [7:0]        hold_q;
  logic [ADDR_W-1:0] ptr_val [2];
  logic [1:0]        ptr_step;
  logic [LEN_W-1:0]  len_val;
  logic              len_hit;
  logic [LIDX_W-1:0] len_idx;
  logic [7:0]        rd_d;
  int                sel_i;

  halt_dma_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_i)
  );

  assign sel_i   = int'(reg_sel);
  assign cfg_wr  = reg_wr && !busy;
  assign ctl_we  = cfg_wr && (sel_i == CTL_OFS);
  assign go      = ctl_we && reg_wdata[MODE_GO];
  assign sts_clr = reg_wr && (sel_i == STS_OFS) && reg_wdata[STAT_DONE];

  assign ptr_step[0] = bus_rd && src_inc_q;
  assign ptr_step[1] = bus_wr && dst_inc_q;

  // Pointer 0 is the source, pointer 1 the destination; same counter, new base offset.
  for (genvar c = 0; c < 2; c++) begin : g_ptr
    localparam int BASE = c * NB_A;
    logic              hit;
    logic [AIDX_W-1:0] idx;
    always_comb begin
      hit = cfg_wr && (sel_i >= BASE) && (sel_i < BASE + NB_A);
      idx = AIDX_W'(sel_i - BASE);
    end
    halt_dma_cnt #(.W(ADDR_W), .COUNT_DOWN(1'b0)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n_i),
      .wr_en   (hit),
      .wr_idx  (idx),
      .wr_byte (reg_wdata),
      .step    (ptr_step[c]),
      .value   (ptr_val[c])
    );
  end

  always_comb begin
    len_hit = cfg_wr && (sel_i >= LEN_OFS) && (sel_i < LEN_OFS + NB_L);
    len_idx = LIDX_W'(sel_i - LEN_OFS);
  end

  halt_dma_cnt #(.W(LEN_W), .COUNT_DOWN(1'b1)) u_len (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .wr_en   (len_hit),
    .wr_idx  (len_idx),
    .wr_byte (reg_wdata),
    .step    (bus_wr),
    .value   (len_val)
  );

  halt_dma_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .go       (go),
    .cnt_zero (len_val == '0),
    .cnt_last (len_val == LEN_W'(1)),
    .halt_ack (halt_ack),
    .busy     (busy),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .done_set (done_set)
  );

  // Mode bits
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      src_inc_q <= 1'b0;
      dst_inc_q <= 1'b0;
    end else if (ctl_we) begin
      src_inc_q <= reg_wdata[MODE_SRC_INC];
      dst_inc_q <= reg_wdata[MODE_DST_INC];
    end
  end

  // Done flag: completion wins over a clear in the same cycle
  always_comb begin
    done_en = done_set | sts_clr | go;
    done_d  = done_set;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)     done_q <= 1'b0;
    else if (done_en) done_q <= done_d;
  end

  // Byte holding register between the read and the write
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)    hold_q <= '0;
    else if (bus_rd) hold_q <= mem_rdata;
  end

  // Register read-back
  always_comb begin
    rd_d = '0;
    for (int i = 0; i < ADDR_W; i++) begin
      if (sel_i == i / 8)        rd_d[i % 8] = ptr_val[0][i];
      if (sel_i == NB_A + i / 8) rd_d[i % 8] = ptr_val[1][i];
    end
    for (int i = 0; i < LEN_W; i++) begin
      if (sel_i == LEN_OFS + i / 8) rd_d[i % 8] = len_val[i];
    end
    if (sel_i == CTL_OFS) begin
      rd_d[MODE_SRC_INC] = src_inc_q;
      rd_d[MODE_DST_INC] = dst_inc_q;
    end
    if (sel_i == STS_OFS) begin
      rd_d[STAT_BUSY] = busy;
      rd_d[STAT_DONE] = done_q;
    end
  end

  assign reg_rdata = rd_d;
  assign irq       = done_q;
  assign halt_req  = busy;
  assign mem_rd    = bus_rd;
  assign mem_wr    = bus_wr;
  assign mem_addr  = bus_wr ? ptr_val[1] : ptr_val[0];
  assign mem_wdata = hold_q;
endmodule

// File: rtl/halt_dma_chk.sv
module halt_dma_chk #(
  parameter int REG_AW  = 4,
  parameter int STS_OFS = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic [REG_AW-1:0] reg_sel,
  input logic              reg_wr,
  input logic              clr_bit,
  input logic              irq,
  input logic              halt_req,
  input logic              halt_ack,
  input logic              mem_rd,
  input logic              mem_wr
);
  a_r2_no_strobe_without_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> (halt_ack && halt_req));

  a_r3_one_strobe_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  a_r3_read_not_repeated: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);

  a_r8_irq_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !halt_req);

  a_r8_release_flags_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halt_req) |-> irq);

  a_r9_clear_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (int'(reg_sel) == STS_OFS) && clr_bit && !halt_req) |=> !irq);
endmodule

bind halt_dma halt_dma_chk #(.REG_AW(REG_AW), .STS_OFS(STS_OFS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_sel  (reg_sel),
  .reg_wr   (reg_wr),
  .clr_bit  (reg_wdata[1]),
  .irq      (irq),
  .halt_req (halt_req),
  .halt_ack (halt_ack),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr)
);

// File: tb/halt_dma_tb.sv
module halt_dma_tb;
  localparam int SRC0 = 'h300FE;
  localparam int DST0 = 'hA0800;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_sel = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        irq;
  logic        halt_req;
  logic        halt_ack = 1'b0;
  logic [19:0] mem_addr;
  logic        mem_rd;
  logic        mem_wr;
  logic [7:0]  mem_rdata;
  logic [7:0]  mem_wdata;

  logic [7:0]  mem [4096];
  int n_checks = 0, n_err = 0;
  int n_rd = 0, n_wr = 0, n_bad = 0;
  logic mon_clr = 1'b0;
  int ack_lat = 0, ack_cnt = 0;

  always #2 clk = ~clk;

  halt_dma u_dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .halt_req(halt_req), .halt_ack(halt_ack), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata)
  );

  assign mem_rdata = mem[mem_addr[11:0]];

  always @(posedge clk) if (mem_wr) mem[mem_addr[11:0]] <= mem_wdata;

  // Grant model: acknowledge after ack_lat cycles of request
  always @(posedge clk) begin
    if (!halt_req) begin
      halt_ack <= 1'b0;
      ack_cnt  <= 0;
    end else if (ack_cnt >= ack_lat) halt_ack <= 1'b1;
    else ack_cnt <= ack_cnt + 1;
  end

  // Bus monitor
  always @(posedge clk) begin
    if (mon_clr) begin
      n_rd <= 0; n_wr <= 0; n_bad <= 0;
    end else begin
      if (mem_rd) n_rd <= n_rd + 1;
      if (mem_wr) n_wr <= n_wr + 1;
      if ((mem_rd || mem_wr) && !halt_ack) n_bad <= n_bad + 1;
      if (mem_rd && mem_addr[19:12] != 8'h30) n_bad <= n_bad + 1;
      if (mem_wr && mem_addr[19:12] != 8'hA0) n_bad <= n_bad + 1;
    end
  end

  function automatic logic [7:0] pat(int i);
    return 8'((i * 7 + 3) ^ (i >> 4));
  endfunction

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(int sel, int data);
    @(negedge clk);
    reg_sel = 4'(sel); reg_wdata = 8'(data); reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(int sel, output int val);
    reg_sel = 4'(sel);
    #1;
    val = int'(reg_rdata);
  endtask

  task automatic rd_multi(int base, int nb, output int val);
    int b;
    val = 0;
    for (int k = 0; k < nb; k++) begin
      rd_reg(base + k, b);
      val = val | (b << (8 * k));
    end
  endtask

  task automatic load_multi(int base, int nb, int val);
    for (int k = 0; k < nb; k++) wr_reg(base + k, (val >> (8 * k)) & 'hFF);
  endtask

  task automatic run(int len, bit si, bit di, int lat, bit poke);
    int v, exp, waited;
    for (int i = 0; i < 4096; i++) mem[i] = pat(i);
    ack_lat = lat;
    @(negedge clk); mon_clr = 1'b1;
    @(negedge clk); mon_clr = 1'b0;
    load_multi(0, 3, SRC0);
    load_multi(3, 3, DST0);
    load_multi(6, 2, len);
    wr_reg(8, {29'd0, di, si, 1'b1});
    if (len == 0) begin
      chk("R7 irq at once", int'(irq), 1);
      chk("R7 no halt", int'(halt_req), 0);
      rd_reg(9, v); chk("R7 status", v, 2);
      repeat (3) @(negedge clk);
      chk("R7 no strobes", n_rd + n_wr, 0);
    end else begin
      chk("R2 halt raised", int'(halt_req), 1);
      rd_reg(9, v); chk("R9 busy status", v, 1);
      if (poke) begin
        load_multi(0, 3, 'h11111);
        load_multi(3, 3, 'h22222);
        load_multi(6, 2, 'h5555);
        wr_reg(8, 'h01);
      end
      waited = 0;
      while (n_wr < len && waited < 5000) begin
        @(negedge clk); waited++;
      end
      chk("R8 halt released", int'(halt_req), 0);
      chk("R8 irq raised", int'(irq), 1);
      repeat (3) @(negedge clk);
      chk("R6 write count", n_wr, len);
      chk("R3 read count", n_rd, len);
      chk("R2 strobe discipline", n_bad, 0);
      for (int k = 0; k < (di ? len : 1); k++) begin
        exp = si ? (di ? pat('h0FE + k) : pat('h0FE + len - 1)) : pat('h0FE);
        chk("R3 R4 dest byte", int'(mem['h800 + k]), exp);
      end
      if (!di) chk("R4 fixed dest neighbour", int'(mem['h801]), int'(pat('h801)));
      rd_multi(0, 3, v); chk("R4 R5 src pointer", v, SRC0 + (si ? len : 0));
      rd_multi(3, 3, v); chk("R4 R5 dst pointer", v, DST0 + (di ? len : 0));
      rd_multi(6, 2, v); chk("R6 count end", v, 0);
      rd_reg(8, v); chk("R10 mode kept", v, {di, si, 1'b0});
      rd_reg(9, v); chk("R9 done status", v, 2);
    end
    wr_reg(9, 2);
    chk("R9 irq cleared", int'(irq), 0);
    rd_reg(9, v); chk("R9 status cleared", v, 0);
  endtask

  initial begin
    #800000;
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    int v;
    int lens[7] = '{0, 1, 2, 3, 5, 16, 259};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 halt_req", int'(halt_req), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 strobes", int'(mem_rd) + int'(mem_wr), 0);
    for (int s = 0; s < 10; s++) begin
      rd_reg(s, v); chk("R1 register zero", v, 0);
    end
    // R5 byte loading and top-byte masking
    load_multi(0, 3, 'hFFFFFF);
    rd_reg(2, v); chk("R5 top byte masked", v, 'h0F);
    rd_multi(0, 3, v); chk("R5 src load", v, 'hFFFFF);
    load_multi(3, 3, 'h5A3C1);
    rd_multi(3, 3, v); chk("R5 dst load", v, 'h5A3C1);
    // Sweep
    for (int li = 0; li < 6; li++)
      for (int m = 0; m < 4; m++)
        for (int l = 0; l < 2; l++)
          run(lens[li], m[0], m[1], l * 2, 1'b0);
    run(lens[6], 1'b1, 1'b1, 1, 1'b0);
    // R10 lockout during a slow grant
    run(4, 1'b1, 1'b1, 30, 1'b1);
    run(3, 1'b0, 1'b1, 30, 1'b1);
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule